// File: doc/BRIEF.md
# Phase-Accumulator Tick Generator

This block is a single-channel numerically controlled oscillator. A 16-bit step word is added, modulo 2^16, to a phase accumulator on every reference clock. The accumulator's top bit is the square-wave output, so its frequency is the effective step divided by 65536, times the reference frequency. A step at or above half scale behaves like its two's-complement value, 65536 minus the step, because the top bit wraps at the same rate either way.

Alongside the square wave, the block raises a one-cycle tick each time the square wave goes high. A downstream constant-frequency PWM stage uses this tick as its clock enable. The square wave can also be routed straight to a channel pin.

Software loads the step word one byte at a time. The upper byte is parked in a holding register. Writing the lower byte commits the full word in a single step, so a word that is only half updated never reaches the accumulator. A step of zero freezes the accumulator.

Top module: `nco_tick_gen`

## Requirements
- R1: After reset, sqOut is 0, tickOut is 0 and the active step is zero, so no tick appears until a step is committed.
- R2: Each clock adds the active step to the 16-bit accumulator modulo 2^16. sqOut is bit 15 of the accumulator. Over any whole number of accumulator wraps, the tick count equals cycles × step / 65536 (for example, step 0x0300 gives 3 ticks in 256 cycles).
- R3: A step S with S ≥ 0x8000 gives the same tick rate as step 65536 − S (for example, 0xC000 and 0x4000 both give one tick every 4 cycles).
- R4: A power-of-two step from 0x0001 to 0x8000 gives an exact 50% duty sqOut: high for half of every period. Step 0x8000 toggles sqOut on every clock.
- R5: tickOut is high for exactly one cycle, in the first cycle that sqOut is high after being low, and at no other time.
- R6: A write to the upper byte alone (wrHiEn) does not change the active step or the output rate.
- R7: A write to the lower byte (wrLoEn) commits {held upper byte, wrData} as the active step at that clock edge. The accumulator uses the new step from the next edge on.
- R8: If wrHiEn and wrLoEn are asserted in the same cycle, the commit uses the upper byte held before that cycle, and wrData becomes the new held upper byte.
- R9: With an active step of zero, the accumulator does not advance: sqOut keeps its level and no tick is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrHiEn | input | 1 | Write strobe for the upper step byte (held only) |
| wrLoEn | input | 1 | Write strobe for the lower step byte (commits the word) |
| wrData | input | 8 | Byte written by either strobe |
| sqOut | output | 1 | Square-wave output, accumulator bit 15 |
| tickOut | output | 1 | One-cycle pulse on each rising edge of sqOut |

## Verification
Two things can happen on the same clock edge: a lower-byte commit and a rising edge of the accumulator's top bit. The bench commits new steps while a fast step is running. This lines commit edges up with output edges. A cycle-accurate model is compared with sqOut and tickOut on every cycle, so a tick that is lost or doubled at the hand-over is caught. The simultaneous upper-and-lower write is judged by the tick rate it produces. A commit of the held byte and a commit of the fresh byte differ by a factor of 32.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int CwBits   = 16;
  localparam int ByteBits = 8;

  // control -> datapath strobes
  typedef struct packed {
    logic              commit;
    logic [CwBits-1:0] word;
  } cwStrobeT;
endpackage

// File: rtl/nco_cw_ctrl.sv
module nco_cw_ctrl
  import nco_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrHiEn,
  input  logic                wrLoEn,
  input  logic [ByteBits-1:0] wrData,
  output cwStrobeT            strb
);
  localparam int HiBits = CwBits - ByteBits;

  logic [HiBits-1:0] shadowHi;

  // upper byte waits here until the lower byte commits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      shadowHi <= '0;
    else if (wrHiEn) shadowHi <= wrData[HiBits-1:0];
  end

  // a simultaneous upper write lands in the shadow after this commit (R8)
  always_comb begin
    strb.commit = wrLoEn;
    strb.word   = {shadowHi, wrData};
  end
endmodule

// File: rtl/nco_phase_dp.sv
module nco_phase_dp
  import nco_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cwStrobeT          strb,
  output logic [CwBits-1:0] curWord,
  output logic              sqOut,
  output logic              tickOut
);
  localparam int MsbIdx = CwBits - 1;
  localparam logic [CwBits-1:0] HalfScale = CwBits'(1) << MsbIdx;

  logic [CwBits-1:0] activeWord;
  logic [CwBits-1:0] acc;
  logic              prevMsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      activeWord <= '0;
      acc        <= '0;
      prevMsb    <= 1'b0;
    end else begin
      if (strb.commit) activeWord <= strb.word;
      acc     <= acc + activeWord;   // wraps modulo 2^CwBits
      prevMsb <= acc[MsbIdx];
    end
  end

  assign curWord = activeWord;
  assign sqOut   = acc[MsbIdx];
  assign tickOut = acc[MsbIdx] & ~prevMsb;

  p_tick_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqOut) |-> tickOut);
  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (activeWord == '0) |=> $stable(sqOut) && !tickOut);
  p_half_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (activeWord == HalfScale) |=> (sqOut != $past(sqOut)));
  p_hold_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.commit |=> $stable(activeWord));
endmodule

// File: rtl/nco_tick_gen.sv
module nco_tick_gen
  import nco_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrHiEn,
  input  logic                wrLoEn,
  input  logic [ByteBits-1:0] wrData,
  output logic                sqOut,
  output logic                tickOut
);
  cwStrobeT          strb;
  logic [CwBits-1:0] curWord;

  nco_cw_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrHiEn (wrHiEn),
    .wrLoEn (wrLoEn),
    .wrData (wrData),
    .strb   (strb)
  );

  nco_phase_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .curWord (curWord),
    .sqOut   (sqOut),
    .tickOut (tickOut)
  );

  // low byte of a commit always comes from the write data (R7)
  p_commit_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrLoEn |=> (curWord[ByteBits-1:0] == $past(wrData)));
endmodule

// File: tb/nco_tick_gen_test.sv
module nco_tick_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrHiEn = 1'b0;
  logic       wrLoEn = 1'b0;
  logic [7:0] wrData = '0;
  logic       sqOut, tickOut;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  bit  modelOn = 1'b0;

  // spec model of the accumulator
  logic [15:0] mAcc = '0, mWord = '0;
  logic [7:0]  mHi = '0;
  logic        mPrev = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nco_tick_gen uut (
    .clk(clk), .rst_n(rst_n), .wrHiEn(wrHiEn), .wrLoEn(wrLoEn),
    .wrData(wrData), .sqOut(sqOut), .tickOut(tickOut)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mAcc = '0; mWord = '0; mHi = '0; mPrev = 1'b0;
    end else begin
      mPrev = mAcc[15];
      mAcc  = mAcc + mWord;
      if (wrLoEn) mWord = {mHi, wrData};
      if (wrHiEn) mHi = wrData;
    end
  end

  // cycle-by-cycle comparison (R2, R5)
  always @(negedge clk) begin
    if (modelOn && rst_n) begin
      check(sqOut == mAcc[15], "R2 sqOut", int'(sqOut), int'(mAcc[15]));
      check(tickOut == (mAcc[15] & ~mPrev), "R5 tickOut", int'(tickOut),
            int'(mAcc[15] & ~mPrev));
    end
  end

  task automatic writeHi(input logic [7:0] b);
    @(negedge clk); wrHiEn = 1'b1; wrData = b;
    @(negedge clk); wrHiEn = 1'b0;
  endtask

  task automatic writeLo(input logic [7:0] b);
    @(negedge clk); wrLoEn = 1'b1; wrData = b;
    @(negedge clk); wrLoEn = 1'b0;
  endtask

  task automatic writeWord(input logic [15:0] w);
    writeHi(w[15:8]);
    writeLo(w[7:0]);
  endtask

  task automatic countTicks(input int n, output int t, output int h);
    t = 0; h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      t += int'(tickOut);
      h += int'(sqOut);
    end
  endtask

  task automatic t_reset;
    int t, h;
    check(sqOut == 1'b0, "R1 sqOut at reset", int'(sqOut), 0);
    check(tickOut == 1'b0, "R1 tickOut at reset", int'(tickOut), 0);
    countTicks(20, t, h);
    check(t == 0, "R1 no ticks with zero step", t, 0);
  endtask

  task automatic t_rate;
    int t, h;
    writeWord(16'h0300);
    countTicks(256, t, h);
    check(t == 3, "R2 step 0x0300 ticks/256", t, 3);
    writeWord(16'h0100);
    countTicks(512, t, h);
    check(t == 2, "R2 step 0x0100 ticks/512", t, 2);
  endtask

  task automatic t_alias;
    int t, h;
    writeWord(16'h4000);
    countTicks(64, t, h);
    check(t == 16, "R3 step 0x4000", t, 16);
    writeWord(16'hC000);
    countTicks(64, t, h);
    check(t == 16, "R3 step 0xC000 aliases 0x4000", t, 16);
    writeWord(16'hE000);
    countTicks(64, t, h);
    check(t == 8, "R3 step 0xE000 aliases 0x2000", t, 8);
  endtask

  task automatic t_duty;
    int t, h;
    writeWord(16'h0800);
    countTicks(64, t, h);
    check(h == 32, "R4 step 0x0800 high cycles", h, 32);
    check(t == 2, "R4 step 0x0800 ticks", t, 2);
    writeWord(16'h8000);
    countTicks(64, t, h);
    check(h == 32, "R4 step 0x8000 high cycles", h, 32);
    check(t == 32, "R5 step 0x8000 ticks", t, 32);
  endtask

  task automatic t_hiOnly;
    int t, h;
    writeWord(16'h4000);
    writeHi(8'h01);
    countTicks(64, t, h);
    check(t == 16, "R6 upper write alone keeps rate", t, 16);
    writeLo(8'h00);
    countTicks(512, t, h);
    check(t == 2, "R7 lower write commits 0x0100", t, 2);
  endtask

  task automatic t_simul;
    int t, h;
    writeHi(8'h01);
    @(negedge clk); wrHiEn = 1'b1; wrLoEn = 1'b1; wrData = 8'h20;
    @(negedge clk); wrHiEn = 1'b0; wrLoEn = 1'b0;
    countTicks(256, t, h);
    check(t == 1, "R8 commit uses held upper byte (0x0120)", t, 1);
    writeLo(8'h00);
    countTicks(64, t, h);
    check(t == 8, "R8 new upper byte held (0x2000)", t, 8);
  endtask

  task automatic t_zero;
    int t, h;
    logic lvl;
    writeWord(16'h0000);
    @(negedge clk);
    lvl = sqOut;
    countTicks(50, t, h);
    check(t == 0, "R9 no ticks with zero step", t, 0);
    check(h == (lvl ? 50 : 0), "R9 level held", h, lvl ? 50 : 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    modelOn = 1'b1;
    t_reset();
    t_rate();
    t_alias();
    t_duty();
    t_hiOnly();
    t_simul();
    t_zero();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule